// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the integer register store of a 32-bit load-store processor core. It holds thirty-one general-purpose physical words, five saved-status words and one current-status word. Logical registers r0 to r15 are steered onto those words according to the processor mode held in the low five bits of the current-status word. Two combinational read ports and one clocked write port serve r0 to r15. A separate write path loads the current-status and saved-status words. Exception entry and exception return strobes perform the status copies that go with a mode change.

The mode field is the block's state machine. Its states are the seven modes: USER, FIQ, IRQ, SUPERVISOR, ABORT, UNDEFINED and SYSTEM. Each cycle, one of three transitions is chosen. ENTER moves to the exception target mode and saves the status word. RETURN restores the status word from the current mode's saved copy. SOFT applies software status loads, or holds the mode when there are none. Reset enters SUPERVISOR.

When the core executes its narrow 16-bit instruction form, a narrow-state input makes every port use only a 3-bit register number. Decode, the ALU and exception arbitration sit outside this block and drive its strobes.

Top module: `banked_regfile`

## Requirements
- R1: After reset the current-status word reads 32'h0000_00D3: SUPERVISOR mode code 10011 in bits 4:0, and bits 7 and 6 set. Every register r0 to r15 reads zero in every mode.
- R2: r0 to r7 and r15 are one physical copy shared by all seven modes.
- R3: r8 to r12 have a private copy in FIQ mode (code 10001). All the other six modes share a single second copy.
- R4: r13 and r14 have a private copy in each of FIQ, IRQ (10010), SUPERVISOR (10011), ABORT (10111) and UNDEFINED (11011). USER (10000) and SYSTEM (11111) share one copy.
- R5: Reads are combinational from the index and the current mode. A write lands at the clock edge, in the physical word chosen by the mode before that edge. A read of the same physical word in the cycle of the write returns the write data.
- R6: While the narrow-state input is high, bit 3 of both read indices and of the write index is ignored, so only r0 to r7 are reachable.
- R7: An entry strobe whose target is one of the five exception-mode codes copies the current-status word into the target's saved-status word. In the same edge it replaces bits 4:0 with the target code and keeps bits 31:5. An entry strobe with any other target code is treated as absent.
- R8: A return strobe in a mode that has a saved-status word loads the current-status word from it. In USER or SYSTEM a return strobe is treated as absent.
- R9: In USER and SYSTEM the saved-status output shows the current-status word, and a saved-status write has no effect. In other modes the output shows that mode's own saved word.
- R10: Any load of the current-status word, from software or from a return, whose bits 4:0 are not one of the seven mode codes takes bits 31:5 and keeps the old mode.
- R11: A valid entry takes precedence over a valid return. Either one discards any software current-status or saved-status write in the same cycle. Without either, both software writes may act together, and the saved-status write uses the mode from before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| narrow_i | input | 1 | Narrow instruction state, limits indices to 3 bits |
| rs_a_idx | input | 4 | Read port A logical register number |
| rs_a_data | output | 32 | Read port A data |
| rs_b_idx | input | 4 | Read port B logical register number |
| rs_b_data | output | 32 | Read port B data |
| rd_we | input | 1 | Register write enable |
| rd_idx | input | 4 | Write logical register number |
| rd_data | input | 32 | Write data |
| exc_take | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode code for entry |
| exc_ret | input | 1 | Exception return strobe |
| cpsr_we | input | 1 | Software current-status write |
| cpsr_wdata | input | 32 | Current-status write data |
| spsr_we | input | 1 | Software saved-status write |
| spsr_wdata | input | 32 | Saved-status write data |
| cpsr_q | output | 32 | Current-status word |
| spsr_q | output | 32 | Saved-status word of the current mode |
| mode_q | output | 5 | Current mode code |

## Verification
The bench targets register aliasing at the bank edges. It checks r7 against r8 and r12 against r13 when moving into and out of FIQ, and the USER/SYSTEM sharing of r13 and r14. A wrong mapper would leak a FIQ value into another mode, or split a shared register. It also checks a write and a read to the same word in one cycle, where a design without the bypass would return stale data. Further cases are an entry strobe that arrives together with a return and a software write, where a design with the wrong priority would corrupt the saved word, and returns or loads that carry an illegal mode code, which a careless design would take into an undefined state.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int MODE_W    = 5;
    localparam int NLOGICAL  = 16;
    localparam int LIDX_W    = $clog2(NLOGICAL);
    localparam int NFIQ_HI   = 5;
    localparam int NEXC      = 5;
    localparam int NGPR      = NLOGICAL + NFIQ_HI + 2 * NEXC;
    localparam int PHYS_W    = $clog2(NGPR);
    localparam int FIQ_BASE  = NLOGICAL;
    localparam int SPL_BASE  = FIQ_BASE + NFIQ_HI;
    localparam int SLOT_W    = $clog2(NEXC);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef enum logic [1:0] {
        ACT_SOFT,
        ACT_ENTER,
        ACT_RETURN
    } act_e;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
               (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_SYS);
    endfunction

    function automatic logic mode_saved(input logic [MODE_W-1:0] m);
        return mode_legal(m) && (m != MODE_USR) && (m != MODE_SYS);
    endfunction

    function automatic logic [SLOT_W-1:0] saved_slot(input logic [MODE_W-1:0] m);
        logic [SLOT_W-1:0] s;
        case (m)
            MODE_FIQ: s = SLOT_W'(0);
            MODE_IRQ: s = SLOT_W'(1);
            MODE_SVC: s = SLOT_W'(2);
            MODE_ABT: s = SLOT_W'(3);
            default:  s = SLOT_W'(4);
        endcase
        return s;
    endfunction

    function automatic logic [PHYS_W-1:0] phys_index(input logic [MODE_W-1:0] m,
                                                     input logic [LIDX_W-1:0] r);
        logic [PHYS_W-1:0] p;
        p = PHYS_W'(r);
        if (r >= LIDX_W'(8) && r <= LIDX_W'(12)) begin
            if (m == MODE_FIQ)
                p = PHYS_W'(FIQ_BASE) + PHYS_W'(r - LIDX_W'(8));
        end else if (r == LIDX_W'(13) || r == LIDX_W'(14)) begin
            if (mode_saved(m))
                p = PHYS_W'(SPL_BASE) + PHYS_W'({saved_slot(m), 1'b0})
                    + PHYS_W'(r - LIDX_W'(13));
        end
        return p;
    endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
    import bank_pkg::*;
#(
    parameter int NPORT = 3
) (
    input  mode_e                              mode_i,
    input  logic                               narrow_i,
    input  logic [NPORT-1:0][LIDX_W-1:0]       idx_i,
    output logic [NPORT-1:0][PHYS_W-1:0]       phys_o
);

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        logic [LIDX_W-1:0] eff;
        always_comb begin
            eff = idx_i[g];
            if (narrow_i)
                eff[LIDX_W-1] = 1'b0;
            phys_o[g] = phys_index(mode_i, eff);
        end
    end

endmodule

// File: rtl/bank_gpr.sv
module bank_gpr
    import bank_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NRD  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [PHYS_W-1:0]             wphys_i,
    input  logic [XLEN-1:0]               wdata_i,
    input  logic [NRD-1:0][PHYS_W-1:0]    rphys_i,
    output logic [NRD-1:0][XLEN-1:0]      rdata_o
);

    logic [XLEN-1:0] store_q [NGPR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGPR; i++)
                store_q[i] <= '0;
        end else if (we_i) begin
            store_q[wphys_i] <= wdata_i;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb begin
            if (we_i && (wphys_i == rphys_i[g]))
                rdata_o[g] = wdata_i;
            else
                rdata_o[g] = store_q[rphys_i[g]];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we_i) && (rphys_i[0] == $past(wphys_i))
         && !(we_i && (wphys_i == rphys_i[0])))
        |-> (rdata_o[0] == $past(wdata_i))); // R5

endmodule

// File: rtl/bank_status.sv
module bank_status
    import bank_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] RESET_STATUS = 32'h0000_00D3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exc_take_i,
    input  logic [MODE_W-1:0]    exc_mode_i,
    input  logic                 exc_ret_i,
    input  logic                 cpsr_we_i,
    input  logic [XLEN-1:0]      cpsr_wdata_i,
    input  logic                 spsr_we_i,
    input  logic [XLEN-1:0]      spsr_wdata_i,
    output mode_e                mode_o,
    output logic [XLEN-1:0]      cpsr_o,
    output logic [XLEN-1:0]      spsr_o
);

    localparam int FLAG_W = XLEN - MODE_W;

    mode_e                        mode_q, mode_d;
    logic [FLAG_W-1:0]            flags_q, flags_d;
    logic [NEXC-1:0][XLEN-1:0]    saved_q, saved_d;
    act_e                         act;
    logic                         take_ok, ret_ok;

    // transition select
    always_comb begin
        take_ok = exc_take_i && mode_saved(exc_mode_i);
        ret_ok  = exc_ret_i && mode_saved(mode_q);
        if (take_ok)
            act = ACT_ENTER;
        else if (ret_ok)
            act = ACT_RETURN;
        else
            act = ACT_SOFT;
    end

    // next state
    always_comb begin
        mode_d  = mode_q;
        flags_d = flags_q;
        saved_d = saved_q;
        unique case (act)
            ACT_ENTER: begin
                saved_d[saved_slot(exc_mode_i)] = {flags_q, mode_q};
                mode_d = mode_e'(exc_mode_i);
            end
            ACT_RETURN: begin
                flags_d = spsr_o[XLEN-1:MODE_W];
                if (mode_legal(spsr_o[MODE_W-1:0]))
                    mode_d = mode_e'(spsr_o[MODE_W-1:0]);
            end
            ACT_SOFT: begin
                if (cpsr_we_i) begin
                    flags_d = cpsr_wdata_i[XLEN-1:MODE_W];
                    if (mode_legal(cpsr_wdata_i[MODE_W-1:0]))
                        mode_d = mode_e'(cpsr_wdata_i[MODE_W-1:0]);
                end
                if (spsr_we_i && mode_saved(mode_q))
                    saved_d[saved_slot(mode_q)] = spsr_wdata_i;
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= MODE_SVC;
            flags_q <= RESET_STATUS[XLEN-1:MODE_W];
            saved_q <= '0;
        end else begin
            mode_q  <= mode_d;
            flags_q <= flags_d;
            saved_q <= saved_d;
        end
    end

    // outputs
    always_comb begin
        mode_o = mode_q;
        cpsr_o = {flags_q, mode_q};
        unique case (mode_q)
            MODE_USR, MODE_SYS: spsr_o = {flags_q, mode_q};
            MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND:
                spsr_o = saved_q[saved_slot(mode_q)];
            default: spsr_o = {flags_q, mode_q};
        endcase
    end

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(mode_q)); // R10

    AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        take_ok |=> ((spsr_o == $past(cpsr_o)) && (cpsr_o[MODE_W-1:0] == $past(exc_mode_i))
                     && (cpsr_o[XLEN-1:MODE_W] == $past(cpsr_o[XLEN-1:MODE_W])))); // R7

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_ok && ret_ok && mode_legal(spsr_o[MODE_W-1:0])) |=> (cpsr_o == $past(spsr_o))); // R8

    AST_SAVED_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_ok && !mode_saved(mode_q)) |=> $stable(saved_q)); // R9

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter logic [XLEN-1:0] RESET_STATUS = 32'h0000_00D3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_i,
    input  logic [3:0]        rs_a_idx,
    output logic [XLEN-1:0]   rs_a_data,
    input  logic [3:0]        rs_b_idx,
    output logic [XLEN-1:0]   rs_b_data,
    input  logic              rd_we,
    input  logic [3:0]        rd_idx,
    input  logic [XLEN-1:0]   rd_data,
    input  logic              exc_take,
    input  logic [4:0]        exc_mode,
    input  logic              exc_ret,
    input  logic              cpsr_we,
    input  logic [XLEN-1:0]   cpsr_wdata,
    input  logic              spsr_we,
    input  logic [XLEN-1:0]   spsr_wdata,
    output logic [XLEN-1:0]   cpsr_q,
    output logic [XLEN-1:0]   spsr_q,
    output logic [4:0]        mode_q
);

    localparam int NRD   = 2;
    localparam int NPORT = NRD + 1;

    mode_e                          cur_mode;
    logic [NPORT-1:0][LIDX_W-1:0]   idx_all;
    logic [NPORT-1:0][PHYS_W-1:0]   phys_all;
    logic [NRD-1:0][PHYS_W-1:0]     rphys;
    logic [NRD-1:0][XLEN-1:0]       rdata;

    assign idx_all = {rd_idx, rs_b_idx, rs_a_idx};
    assign rphys   = phys_all[NRD-1:0];

    bank_status #(.XLEN(XLEN), .RESET_STATUS(RESET_STATUS)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .exc_take_i   (exc_take),
        .exc_mode_i   (exc_mode),
        .exc_ret_i    (exc_ret),
        .cpsr_we_i    (cpsr_we),
        .cpsr_wdata_i (cpsr_wdata),
        .spsr_we_i    (spsr_we),
        .spsr_wdata_i (spsr_wdata),
        .mode_o       (cur_mode),
        .cpsr_o       (cpsr_q),
        .spsr_o       (spsr_q)
    );

    bank_map #(.NPORT(NPORT)) u_map (
        .mode_i   (cur_mode),
        .narrow_i (narrow_i),
        .idx_i    (idx_all),
        .phys_o   (phys_all)
    );

    bank_gpr #(.XLEN(XLEN), .NRD(NRD)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (rd_we),
        .wphys_i (phys_all[NRD]),
        .wdata_i (rd_data),
        .rphys_i (rphys),
        .rdata_o (rdata)
    );

    assign rs_a_data = rdata[0];
    assign rs_b_data = rdata[1];
    assign mode_q    = cur_mode;

    AST_MODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == cpsr_q[4:0]); // R1

    AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (!narrow_i && rs_a_idx == 4'd15) |-> (phys_all[0] == PHYS_W'(15))); // R2

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    localparam logic [4:0] M_USR = 5'b10000;
    localparam logic [4:0] M_FIQ = 5'b10001;
    localparam logic [4:0] M_IRQ = 5'b10010;
    localparam logic [4:0] M_SVC = 5'b10011;
    localparam logic [4:0] M_ABT = 5'b10111;
    localparam logic [4:0] M_UND = 5'b11011;
    localparam logic [4:0] M_SYS = 5'b11111;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        narrow_i = 0;
    logic [3:0]  rs_a_idx = 0, rs_b_idx = 0, rd_idx = 0;
    logic [31:0] rs_a_data, rs_b_data, rd_data = 0;
    logic        rd_we = 0, exc_take = 0, exc_ret = 0, cpsr_we = 0, spsr_we = 0;
    logic [4:0]  exc_mode = 0;
    logic [31:0] cpsr_wdata = 0, spsr_wdata = 0, cpsr_q, spsr_q;
    logic [4:0]  mode_q;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [31:0] view [7][16];
    logic [31:0] saved [7];
    logic [31:0] ref_cpsr;

    always #2 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .narrow_i(narrow_i),
        .rs_a_idx(rs_a_idx), .rs_a_data(rs_a_data),
        .rs_b_idx(rs_b_idx), .rs_b_data(rs_b_data),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .exc_take(exc_take), .exc_mode(exc_mode), .exc_ret(exc_ret),
        .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata),
        .spsr_we(spsr_we), .spsr_wdata(spsr_wdata),
        .cpsr_q(cpsr_q), .spsr_q(spsr_q), .mode_q(mode_q)
    );

    function automatic int mode_num(input logic [4:0] m);
        case (m)
            M_USR: return 0;
            M_FIQ: return 1;
            M_IRQ: return 2;
            M_SVC: return 3;
            M_ABT: return 4;
            M_UND: return 5;
            M_SYS: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic bit has_saved(input int n);
        return (n > 0) && (n < 6);
    endfunction

    function automatic bit shares(input int a, input int b, input int r);
        if (r < 8 || r == 15) return 1;
        if (r <= 12) return (a == 1) == (b == 1);
        if (a == b) return 1;
        return (a == 0 || a == 6) && (b == 0 || b == 6);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        rd_we = 0; exc_take = 0; exc_ret = 0; cpsr_we = 0; spsr_we = 0;
        narrow_i = 0;
    endtask

    task automatic model_reset();
        for (int j = 0; j < 7; j++) begin
            saved[j] = 0;
            for (int r = 0; r < 16; r++) view[j][r] = 0;
        end
        ref_cpsr = 32'h0000_00D3;
    endtask

    // inputs set after a falling edge; compare, clock, update model
    task automatic step(input string tag);
        int m, t;
        logic [3:0] ra, rb, w;
        logic [31:0] ea, eb, es, nv;
        bit take_ok, ret_ok;
        m  = mode_num(ref_cpsr[4:0]);
        ra = narrow_i ? {1'b0, rs_a_idx[2:0]} : rs_a_idx;
        rb = narrow_i ? {1'b0, rs_b_idx[2:0]} : rs_b_idx;
        w  = narrow_i ? {1'b0, rd_idx[2:0]} : rd_idx;
        ea = (rd_we && w == ra) ? rd_data : view[m][ra];
        eb = (rd_we && w == rb) ? rd_data : view[m][rb];
        es = has_saved(m) ? saved[m] : ref_cpsr;
        #1;
        check(tag, "rs_a_data", rs_a_data, ea);
        check(tag, "rs_b_data", rs_b_data, eb);
        check(tag, "cpsr_q", cpsr_q, ref_cpsr);
        check(tag, "spsr_q", spsr_q, es);
        check(tag, "mode_q", {27'd0, mode_q}, {27'd0, ref_cpsr[4:0]});
        @(posedge clk);
        if (rd_we)
            for (int j = 0; j < 7; j++)
                if (shares(m, j, int'(w))) view[j][w] = rd_data;
        t = mode_num(exc_mode);
        take_ok = exc_take && has_saved(t);
        ret_ok  = !take_ok && exc_ret && has_saved(m);
        if (take_ok) begin
            saved[t] = ref_cpsr;
            ref_cpsr[4:0] = exc_mode;
        end else if (ret_ok) begin
            nv = saved[m];
            ref_cpsr = {nv[31:5], (mode_num(nv[4:0]) >= 0) ? nv[4:0] : ref_cpsr[4:0]};
        end else begin
            if (spsr_we && has_saved(m)) saved[m] = spsr_wdata;
            if (cpsr_we)
                ref_cpsr = {cpsr_wdata[31:5],
                            (mode_num(cpsr_wdata[4:0]) >= 0) ? cpsr_wdata[4:0] : ref_cpsr[4:0]};
        end
        @(negedge clk);
        idle();
    endtask

    task automatic set_mode(input logic [4:0] m, input string tag);
        cpsr_we = 1; cpsr_wdata = {ref_cpsr[31:5], m};
        step(tag);
    endtask

    task automatic wr(input int r, input logic [31:0] d, input string tag);
        rd_we = 1; rd_idx = 4'(r); rd_data = d;
        rs_a_idx = 4'(r); rs_b_idx = 4'(r ^ 1);
        step(tag);
    endtask

    task automatic rd(input int a, input int b, input string tag);
        rs_a_idx = 4'(a); rs_b_idx = 4'(b);
        step(tag);
    endtask

    function automatic logic [4:0] pick_mode(input int k);
        case (k % 7)
            0: return M_USR; 1: return M_FIQ; 2: return M_IRQ; 3: return M_SVC;
            4: return M_ABT; 5: return M_UND; default: return M_SYS;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        model_reset();
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int r = 0; r < 16; r += 2) rd(r, r + 1, "R1");

        // R2 shared low registers and pc written in supervisor
        for (int r = 0; r < 16; r++) wr(r, 32'hA000_0000 + r, "R2");
        set_mode(M_FIQ, "R3");
        for (int r = 8; r < 15; r++) wr(r, 32'hF100_0000 + r, "R3");
        rd(7, 8, "R3");
        rd(12, 13, "R4");
        set_mode(M_USR, "R4");
        for (int r = 0; r < 16; r += 2) rd(r, r + 1, "R2");
        wr(13, 32'h5555_0013, "R4");
        set_mode(M_SYS, "R4");
        rd(13, 14, "R4");
        set_mode(M_IRQ, "R4");
        rd(13, 12, "R4");
        set_mode(M_UND, "R4");
        wr(14, 32'hDDDD_0014, "R4");
        set_mode(M_ABT, "R4");
        rd(14, 13, "R4");

        // R5 bypass on both ports
        rd_we = 1; rd_idx = 4'd3; rd_data = 32'h1234_5678;
        rs_a_idx = 4'd3; rs_b_idx = 4'd3; step("R5");
        rd(3, 4, "R5");

        // R6 narrow state
        narrow_i = 1; rs_a_idx = 4'd9; rs_b_idx = 4'd15; step("R6");
        narrow_i = 1; rd_we = 1; rd_idx = 4'd13; rd_data = 32'hCAFE_0005;
        rs_a_idx = 4'd5; rs_b_idx = 4'd13; step("R6");
        rd(5, 13, "R6");

        // R7 entry, then R8 return
        set_mode(M_USR, "R7");
        exc_take = 1; exc_mode = M_IRQ; step("R7");
        rd(13, 14, "R7");
        exc_take = 1; exc_mode = 5'b00110; step("R7");
        exc_take = 1; exc_mode = M_SYS; step("R7");
        exc_ret = 1; step("R8");
        exc_ret = 1; step("R8");

        // R9 saved-status in user and system
        spsr_we = 1; spsr_wdata = 32'h0BAD_0000; step("R9");
        set_mode(M_SYS, "R9");
        spsr_we = 1; spsr_wdata = 32'h0BAD_1111; step("R9");
        set_mode(M_SVC, "R9");
        spsr_we = 1; spsr_wdata = 32'h6000_0010; step("R9");

        // R10 illegal mode loads
        cpsr_we = 1; cpsr_wdata = 32'hF000_0005; step("R10");
        spsr_we = 1; spsr_wdata = 32'h8000_0001; step("R10");
        exc_ret = 1; step("R10");

        // R11 priority
        exc_take = 1; exc_mode = M_ABT; exc_ret = 1;
        cpsr_we = 1; cpsr_wdata = {27'h1, M_USR};
        spsr_we = 1; spsr_wdata = 32'h7777_7777; step("R11");
        exc_ret = 1; cpsr_we = 1; cpsr_wdata = {27'h2, M_FIQ};
        spsr_we = 1; spsr_wdata = 32'h3333_3333; step("R11");
        cpsr_we = 1; cpsr_wdata = {27'h3, M_IRQ};
        spsr_we = 1; spsr_wdata = 32'h4444_4444; step("R11");
        rd(0, 0, "R11");

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            rs_a_idx   = 4'($urandom(seed) % 16); seed++;
            rs_b_idx   = 4'($urandom(seed) % 16); seed++;
            rd_idx     = 4'($urandom(seed) % 16); seed++;
            rd_data    = $urandom(seed); seed++;
            rd_we      = ($urandom(seed) % 2) == 0; seed++;
            narrow_i   = ($urandom(seed) % 6) == 0; seed++;
            exc_take   = ($urandom(seed) % 8) == 0; seed++;
            exc_mode   = (($urandom(seed) % 10) == 0) ? 5'($urandom(seed + 1))
                                                      : pick_mode($urandom(seed + 2)); seed += 3;
            exc_ret    = ($urandom(seed) % 8) == 0; seed++;
            cpsr_we    = ($urandom(seed) % 8) == 0; seed++;
            cpsr_wdata = {27'($urandom(seed)),
                          (($urandom(seed + 1) % 5) == 0) ? 5'($urandom(seed + 2))
                                                          : pick_mode($urandom(seed + 3))};
            seed += 4;
            spsr_we    = ($urandom(seed) % 6) == 0; seed++;
            spsr_wdata = {27'($urandom(seed)), pick_mode($urandom(seed + 1))}; seed += 2;
            step("mixed R2 R3 R4 R5 R11");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule